// File: doc/BRIEF.md
# Control Endpoint Handshake Sequencer

This block is the device-side decision logic for the default control endpoint of a USB function. A serial interface engine gives it one-cycle strobes for decoded SETUP, IN and OUT tokens and for a host ACK that follows a data packet the device sent. For each token, the block selects the handshake or response one cycle later: ACK, NAK, STALL, a data packet taken from the transmit buffer, or a zero-length DATA1 status packet. FIFO storage, CRC, bit stuffing and serialization are handled elsewhere.

Firmware controls the block through an 8-bit control and acknowledge register. The upper nibble holds four control bits: transfer direction, data end, force stall and transmit packet ready. The lower nibble holds four event flags, which the hardware sets and firmware clears by writing a 1. The sequencer tracks the transfer through three phases: idle, setup or data, and status. It moves into the status phase on its own once data end is set and no packet is left to send. It chooses the status handshake from the direction bit. It never clears data end.

Top module: `ep0_handshake_seq`

## Requirements
- R1: After reset, the register reads 0x00, `hs_valid`, `tx_start` and `irq` are 0, and the phase is idle.
- R2: A firmware write loads bits 7..4 of the register from `reg_wdata`: bit 7 direction (1 = control read), bit 6 data end, bit 5 force stall, bit 4 transmit packet ready. These bits read back on `reg_rdata`. A write to an idle endpoint produces no handshake.
- R3: Bits 3..0 are flags: bit 3 stall sent, bit 2 setup received, bit 1 OUT received, bit 0 transmit complete. Writing a 1 to a flag clears it, and writing a 0 leaves it unchanged. If the hardware sets a flag in the same cycle that firmware clears it, the flag stays 1.
- R4: A SETUP token is always answered with ACK (`hs_code` 0). It sets the setup-received flag, clears force stall and places the sequencer in the setup/data phase.
- R5: While force stall is 1, an IN or OUT token is answered with STALL (`hs_code` 2) and sets the stall-sent flag. This includes the status stage of a transfer that has no data stage.
- R6: An IN token outside the status phase, with force stall 0 and transmit packet ready 1, is answered with a data packet (`hs_code` 3) and a `tx_start` pulse. A following `host_ack` clears transmit packet ready and sets the transmit-complete flag.
- R7: An IN token outside the status phase, with force stall 0, transmit packet ready 0 and data end 0, is answered with NAK (`hs_code` 1) and no `tx_start`.
- R8: In the setup/data phase, with data end 1 and transmit packet ready 0, the status phase begins. With direction 0, an IN token is then answered with a zero-length DATA1 packet (`hs_code` 4) and a `tx_start` pulse. The host's ACK sets the transmit-complete flag, leaves data end at 1 and returns the sequencer to idle, where a later IN gets NAK.
- R9: With direction 1, the status phase is entered after the last packet, sent with data end 1, has been ACKed. In that phase an IN gets NAK, and an OUT gets ACK, sets the OUT-received flag and ends the transfer with data end still 1. Outside the status phase an OUT without stall gets ACK and sets the OUT-received flag.
- R10: `irq[i]` is high exactly when flag bit i is 1 and `irq_en[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_setup | input | 1 | SETUP token decoded (one-cycle strobe) |
| tok_in | input | 1 | IN token decoded (one-cycle strobe) |
| tok_out | input | 1 | OUT token decoded (one-cycle strobe) |
| host_ack | input | 1 | Host ACK received for the last packet sent |
| reg_wr | input | 1 | Firmware register write strobe |
| reg_wdata | input | 8 | Firmware write data |
| irq_en | input | 4 | Interrupt enable for each flag bit |
| reg_rdata | output | 8 | Current register contents |
| hs_valid | output | 1 | Response selected this cycle |
| hs_code | output | 3 | 0 ACK, 1 NAK, 2 STALL, 3 data, 4 zero-length DATA1 |
| tx_start | output | 1 | Start sending a packet from the transmit buffer |
| irq | output | 4 | Interrupt requests, one for each flag |

## Verification
The assertions check the following on every cycle:
- every SETUP gets ACK and leaves force stall cleared;
- a forced stall wins over any IN or OUT;
- an IN with nothing loaded and no data end gets NAK;
- `tx_start` only comes with a data or status packet;
- a host ACK of a data packet clears transmit packet ready;
- data end never falls without a firmware write.

Only the bench scenarios can show the full phase sequences. These are a control write that ends in a zero-length IN status, a control read that ends in an OUT status, and a stalled transfer with no data stage. The bench also checks the set-over-clear race on a flag and the interrupt gating.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

    localparam int REG_W  = 8;
    localparam int FLAG_N = 4;
    localparam int CODE_W = 3;

    // flag bit positions (low nibble of the register)
    localparam int F_TXC   = 0;
    localparam int F_OUTRX = 1;
    localparam int F_SETUP = 2;
    localparam int F_STALL = 3;

    typedef enum logic [CODE_W-1:0] {
        HS_ACK   = 3'd0,
        HS_NAK   = 3'd1,
        HS_STALL = 3'd2,
        HS_DATA  = 3'd3,
        HS_ZLP1  = 3'd4
    } hs_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_XFER   = 2'd1,
        PH_STATUS = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        PD_NONE = 2'd0,
        PD_DATA = 2'd1,
        PD_ZLP  = 2'd2
    } pend_e;

    // upper nibble, bit 7 down to bit 4
    typedef struct packed {
        logic dir;
        logic dend;
        logic stall;
        logic txpr;
    } ctl_t;

endpackage

// File: rtl/ep0_ctl_bits.sv
module ep0_ctl_bits
    import ep0_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic [3:0] wnib,
    input  logic clr_stall,
    input  logic clr_txpr,
    output ctl_t ctl
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) ctl_d = ctl_t'(wnib);
        // hardware actions override a same-cycle firmware write
        if (clr_stall) ctl_d.stall = 1'b0;
        if (clr_txpr)  ctl_d.txpr  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/ep0_ack_flags.sv
module ep0_ack_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wclr,
    input  logic [N-1:0] set,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic [N-1:0] irq
);

    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            flag_d[i] = flag_q[i];
            if (wr && wclr[i]) flag_d[i] = 1'b0;
            if (set[i])        flag_d[i] = 1'b1;
        end
        assign irq[i] = flag_q[i] & en[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;

endmodule

// File: rtl/ep0_phase_fsm.sv
module ep0_phase_fsm
    import ep0_seq_pkg::*;
#(
    parameter int NF = FLAG_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tok_setup,
    input  logic               tok_in,
    input  logic               tok_out,
    input  logic               host_ack,
    input  ctl_t               ctl,
    output logic [NF-1:0]      ev,
    output logic               clr_stall,
    output logic               clr_txpr,
    output logic               hs_valid,
    output logic [CODE_W-1:0]  hs_code,
    output logic               tx_start
);

    typedef struct packed {
        phase_e phase;
        pend_e  pend;
        logic   hs_valid;
        hs_e    code;
        logic   tx_start;
    } st_t;

    st_t    st_d, st_q;
    phase_e eff;

    always_comb begin
        st_d          = st_q;
        st_d.hs_valid = 1'b0;
        st_d.tx_start = 1'b0;
        ev            = '0;
        clr_stall     = 1'b0;
        clr_txpr      = 1'b0;

        // the status phase opens once data end is set and nothing is left to send
        eff = st_q.phase;
        if (st_q.phase == PH_XFER && ctl.dend && !ctl.txpr && st_q.pend == PD_NONE)
            eff = PH_STATUS;

        if (host_ack) begin
            if (st_q.pend == PD_DATA) begin
                clr_txpr    = 1'b1;
                ev[F_TXC]   = 1'b1;
            end else if (st_q.pend == PD_ZLP) begin
                ev[F_TXC]   = 1'b1;
                st_d.phase  = PH_IDLE;
            end
            st_d.pend = PD_NONE;
        end

        if (tok_setup) begin
            st_d.hs_valid = 1'b1;
            st_d.code     = HS_ACK;
            st_d.phase    = PH_XFER;
            st_d.pend     = PD_NONE;
            ev[F_SETUP]   = 1'b1;
            clr_stall     = 1'b1;
        end else if (tok_in) begin
            st_d.hs_valid = 1'b1;
            st_d.pend     = PD_NONE;
            if (ctl.stall) begin
                st_d.code   = HS_STALL;
                ev[F_STALL] = 1'b1;
            end else if (eff == PH_STATUS) begin
                st_d.phase = PH_STATUS;
                if (!ctl.dir) begin
                    st_d.code     = HS_ZLP1;
                    st_d.tx_start = 1'b1;
                    st_d.pend     = PD_ZLP;
                end else begin
                    st_d.code = HS_NAK;
                end
            end else if (ctl.txpr) begin
                st_d.code     = HS_DATA;
                st_d.tx_start = 1'b1;
                st_d.pend     = PD_DATA;
            end else begin
                st_d.code = HS_NAK;
            end
        end else if (tok_out) begin
            st_d.hs_valid = 1'b1;
            st_d.pend     = PD_NONE;
            if (ctl.stall) begin
                st_d.code   = HS_STALL;
                ev[F_STALL] = 1'b1;
            end else if (eff == PH_STATUS) begin
                if (ctl.dir) begin
                    st_d.code   = HS_ACK;
                    ev[F_OUTRX] = 1'b1;
                    st_d.phase  = PH_IDLE;
                end else begin
                    st_d.code  = HS_NAK;
                    st_d.phase = PH_STATUS;
                end
            end else begin
                st_d.code   = HS_ACK;
                ev[F_OUTRX] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, pend: PD_NONE, hs_valid: 1'b0,
                              code: HS_ACK, tx_start: 1'b0};
        else        st_q <= st_d;
    end

    assign hs_valid = st_q.hs_valid;
    assign hs_code  = st_q.code;
    assign tx_start = st_q.tx_start;

endmodule

// File: rtl/ep0_handshake_seq.sv
module ep0_handshake_seq
    import ep0_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_setup,
    input  logic              tok_in,
    input  logic              tok_out,
    input  logic              host_ack,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [FLAG_N-1:0] irq_en,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              hs_valid,
    output logic [CODE_W-1:0] hs_code,
    output logic              tx_start,
    output logic [FLAG_N-1:0] irq
);

    ctl_t              ctl;
    logic [FLAG_N-1:0] ev, flags;
    logic              clr_stall, clr_txpr;

    ep0_ctl_bits u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wnib      (reg_wdata[REG_W-1:FLAG_N]),
        .clr_stall (clr_stall),
        .clr_txpr  (clr_txpr),
        .ctl       (ctl)
    );

    ep0_ack_flags #(.N(FLAG_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wclr  (reg_wdata[FLAG_N-1:0]),
        .set   (ev),
        .en    (irq_en),
        .flags (flags),
        .irq   (irq)
    );

    ep0_phase_fsm #(.NF(FLAG_N)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_setup (tok_setup),
        .tok_in    (tok_in),
        .tok_out   (tok_out),
        .host_ack  (host_ack),
        .ctl       (ctl),
        .ev        (ev),
        .clr_stall (clr_stall),
        .clr_txpr  (clr_txpr),
        .hs_valid  (hs_valid),
        .hs_code   (hs_code),
        .tx_start  (tx_start)
    );

    assign reg_rdata = {ctl, flags};

endmodule

// File: rtl/ep0_seq_chk.sv
module ep0_seq_chk
    import ep0_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tok_setup,
    input logic              tok_in,
    input logic              tok_out,
    input logic              host_ack,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              hs_valid,
    input logic [CODE_W-1:0] hs_code,
    input logic              tx_start
);

    // R4
    setup_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_setup |=> hs_valid && hs_code == HS_ACK);

    // R4
    setup_unstall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_setup |=> !reg_rdata[5]);

    // R5
    stall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tok_setup && (tok_in || tok_out) && reg_rdata[5]) |=> hs_code == HS_STALL);

    // R7
    idle_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tok_setup && tok_in && reg_rdata[6:4] == 3'b000) |=> hs_code == HS_NAK && !tx_start);

    // R6
    txstart_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> hs_valid && (hs_code == HS_DATA || hs_code == HS_ZLP1));

    // R6
    txpr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == HS_DATA && host_ack && !reg_wr
         && !tok_setup && !tok_in && !tok_out) |=> !reg_rdata[4]);

    // R8
    dend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[6] && !reg_wr) |=> reg_rdata[6]);

endmodule

bind ep0_handshake_seq ep0_seq_chk u_chk (.*);

// File: tb/sim_ep0_handshake_seq.sv
module sim_ep0_handshake_seq;
    import ep0_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_setup = 1'b0, tok_in = 1'b0, tok_out = 1'b0, host_ack = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [3:0] irq_en = '0;
    logic [7:0] reg_rdata;
    logic       hs_valid;
    logic [2:0] hs_code;
    logic       tx_start;
    logic [3:0] irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct packed {
        logic [2:0] code;
        logic       txs;
    } exp_t;

    exp_t exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ep0_handshake_seq u0 (.*);

    // monitor: compare each response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && hs_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected response code=%0d (expected none)", hs_code);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (hs_code != e.code || tx_start != e.txs)
                begin
                    errors++;
                    $display("FAIL %s: code=%0d tx_start=%0b expected code=%0d tx_start=%0b",
                             t, hs_code, tx_start, e.code, e.txs);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // driver: one token strobe, expected response pushed to the scoreboard
    task automatic token(input int kind, input hs_e code, input logic txs, input string tag);
        @(negedge clk);
        tok_setup = (kind == 0);
        tok_in    = (kind == 1);
        tok_out   = (kind == 2);
        exp_q.push_back('{code: code, txs: txs});
        tag_q.push_back(tag);
        @(negedge clk);
        tok_setup = 1'b0; tok_in = 1'b0; tok_out = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic hack();
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (R1 run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reg", reg_rdata, 8'h00);
        chk("R1 irq", irq, 4'h0);
        chk("R1 hs_valid", hs_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {hs_valid, tx_start, irq}, 6'h0);

        // R2 control nibble read back, no handshake
        wr(8'hB0); chk("R2 write B0", reg_rdata, 8'hB0);
        wr(8'h0F); chk("R2 write 0F", reg_rdata, 8'h00);

        // control write transfer, R4 R3 R10 R9 R7 R8
        token(0, HS_ACK, 1'b0, "R4 setup");
        chk("R4 setup flag", reg_rdata, 8'h04);
        chk("R10 irq gated off", irq, 4'h0);
        irq_en = 4'b0100; #1;
        chk("R10 irq enabled", irq, 4'b0100);
        irq_en = 4'b0000;
        wr(8'h04); chk("R3 w1c setup", reg_rdata, 8'h00);
        token(2, HS_ACK, 1'b0, "R9 data OUT");
        chk("R9 out flag", reg_rdata, 8'h02);
        wr(8'h02);
        token(1, HS_NAK, 1'b0, "R7 empty IN");
        wr(8'h40); chk("R8 dend written", reg_rdata, 8'h40);
        token(1, HS_ZLP1, 1'b1, "R8 status ZLP");
        hack();
        chk("R8 txc set, dend kept", reg_rdata, 8'h41);
        token(1, HS_NAK, 1'b0, "R8 after status");
        wr(8'h01); chk("R3 w1c txc", reg_rdata, 8'h00);

        // forced stall, R5
        wr(8'h20);
        token(1, HS_STALL, 1'b0, "R5 stall IN");
        chk("R5 stall flag", reg_rdata, 8'h28);
        token(2, HS_STALL, 1'b0, "R5 stall OUT");
        wr(8'h08); chk("R5 flag clear", reg_rdata, 8'h00);

        // control read transfer, R4 R6 R9
        wr(8'h20);
        token(0, HS_ACK, 1'b0, "R4 setup over stall");
        chk("R4 stall cleared", reg_rdata, 8'h04);
        wr(8'h94); chk("R6 loaded", reg_rdata, 8'h90);
        token(1, HS_DATA, 1'b1, "R6 data IN");
        hack();
        chk("R6 txpr cleared", reg_rdata, 8'h81);
        wr(8'hD1); chk("R6 last loaded", reg_rdata, 8'hD0);
        token(1, HS_DATA, 1'b1, "R6 last IN");
        hack();
        chk("R9 last acked", reg_rdata, 8'hC1);
        token(1, HS_NAK, 1'b0, "R9 IN in read status");
        token(2, HS_ACK, 1'b0, "R9 status OUT");
        chk("R9 out flag, dend kept", reg_rdata, 8'hC3);
        wr(8'h03); chk("R9 cleared", reg_rdata, 8'h00);

        // no data stage, stalled status, R5
        token(0, HS_ACK, 1'b0, "R4 setup nodata");
        wr(8'h64); chk("R5 dend+stall", reg_rdata, 8'h60);
        token(1, HS_STALL, 1'b0, "R5 nodata status stall");
        chk("R5 nodata flag", reg_rdata, 8'h68);
        wr(8'h08); chk("R5 cleared", reg_rdata, 8'h00);

        // set beats clear in the same cycle, R3
        token(0, HS_ACK, 1'b0, "R4 setup again");
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 8'h04; tok_setup = 1'b1;
        exp_q.push_back('{code: HS_ACK, txs: 1'b0});
        tag_q.push_back("R3 race setup");
        @(negedge clk);
        reg_wr = 1'b0; tok_setup = 1'b0;
        chk("R3 set wins", reg_rdata, 8'h04);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule